// File: doc/BRIEF.md
# AES Inverse-Cipher Key Deriver

This block produces the key material that an AES decryption datapath needs before it can run its rounds backwards. It takes a 128-, 192- or 256-bit cipher key and runs the forward key expansion, one 32-bit schedule word per clock cycle. It keeps the final schedule words of that expansion in an eight-word output register. Which schedule words it keeps, and in which output slots, depends on the key length.

The key is written through a load port together with a two-bit length code. An accepted load marks the key as needing derivation and withdraws any previous result. A start pulse then launches the expansion, but only while that recompute flag is set, so repeated starts against an unchanged key cost nothing. When the last word has been produced, busy drops and the valid flag rises. The valid flag stays up until the next accepted load. The substitution box is computed arithmetically, as a multiplicative inverse in GF(2^8) followed by the affine map, so no table is stored.

Top module: `aes_dkey_extract`

## Requirements
- R1: `key_code` selects the key length: 0 is 128 bits, taken from `key_data[255:128]`; 1 is 192 bits, from `key_data[255:64]`; 2 is 256 bits, the whole bus. Key word 0 sits at bits [255:224], and each word holds its first byte in its top eight bits. A load with code 3 is rejected. `load_err` is high for exactly the one cycle after it, and the stored key, length, recompute flag, `dkey_valid` and `dkey_out` are left as they were.
- R2: An accepted load sets the recompute flag. In the next cycle `dkey_valid` and `busy` are low, and any derivation in progress is abandoned.
- R3: A start pulse while the recompute flag is set and `busy` is low raises `busy` in the next cycle and clears all eight output words. A start while the flag is clear, or while busy, has no effect on `busy`, `dkey_valid` or `dkey_out`.
- R4: Once started, `busy` stays high for 40, 46 or 52 cycles for 128-, 192- or 256-bit keys. In the following cycle `busy` is low, `dkey_valid` is high and the recompute flag is clear.
- R5: Schedule words follow the standard AES expansion. Every Nk-th word takes the rotate, substitute and round-constant step. For 256-bit keys, the word four past each such word takes a plain substitution.
- R6: For 128-bit keys, output word j (at `dkey_out[255-32j -: 32]`) equals schedule word 40+j for j = 0..3, and output words 4..7 are zero.
- R7: For 192-bit keys, output words 0..3 equal schedule words 48..51, and output words 4..7 equal schedule words 46..49.
- R8: For 256-bit keys, output words 0..3 equal schedule words 56..59, and output words 4..7 equal schedule words 52..55.
- R9: `busy` and `dkey_valid` are never high together. After reset both are low, `load_err` is low and `dkey_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load `key_data` with length `key_code` |
| key_code | input | 2 | Key length code (0/1/2; 3 is illegal) |
| key_data | input | 256 | Cipher key, left-aligned |
| start | input | 1 | Request derivation |
| busy | output | 1 | Expansion in progress |
| dkey_valid | output | 1 | `dkey_out` holds the derived words |
| load_err | output | 1 | One-cycle pulse after a rejected load |
| dkey_out | output | 256 | Eight derived words, word 0 at the top |

## Verification
The bench uses the package defaults: an eight-word output register of 32-bit words and a six-bit schedule index. These reach every length code, including the illegal one. At these values each derivation is short enough that many random keys of every length fit in one run. That brings the full run length, abandoning a run by reloading, a rejected load in mid-run, and repeated starts against an unchanged key all within reach. A published 128-bit test key anchors the final round-key words to known constants.

// File: rtl/aes_dk_pkg.sv
package aes_dk_pkg;
  localparam int WORD_W    = 32;
  localparam int OUT_WORDS = 8;
  localparam int KEY_W     = WORD_W * OUT_WORDS;
  localparam int IDX_W     = 6;

  typedef logic [WORD_W-1:0]             word_t;
  typedef logic [OUT_WORDS-1:0][WORD_W-1:0] wvec_t;

  localparam logic [1:0] KL_128 = 2'd0;
  localparam logic [1:0] KL_192 = 2'd1;
  localparam logic [1:0] KL_256 = 2'd2;
  localparam logic [1:0] KL_BAD = 2'd3;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // x^254 is the field inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (i != 0) r = gf_mul(r, x);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] x);
    logic [7:0] b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

  function automatic logic [3:0] nk_of(input logic [1:0] code);
    case (code)
      KL_128:  return 4'd4;
      KL_192:  return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] code);
    case (code)
      KL_128:  return IDX_W'(43);
      KL_192:  return IDX_W'(51);
      default: return IDX_W'(59);
    endcase
  endfunction

  // schedule index that lands in output slot j; 0 means the slot is never written
  function automatic logic [IDX_W-1:0] slot_src(input logic [1:0] code, input int j);
    case (code)
      KL_128:  return (j < 4) ? IDX_W'(40 + j) : IDX_W'(0);
      KL_192:  return (j < 4) ? IDX_W'(48 + j) : IDX_W'(42 + j);
      default: return (j < 4) ? IDX_W'(56 + j) : IDX_W'(48 + j);
    endcase
  endfunction

  // key words placed so that the newest sits in the highest slot
  function automatic wvec_t load_win(input logic [KEY_W-1:0] key, input logic [1:0] code);
    wvec_t w;
    int    base = OUT_WORDS - int'(nk_of(code));
    for (int j = 0; j < OUT_WORDS; j++) begin
      if (j >= base) w[j] = key[KEY_W-1-WORD_W*(j-base) -: WORD_W];
      else           w[j] = '0;
    end
    return w;
  endfunction
endpackage

// File: rtl/aes_dk_subword.sv
module aes_dk_subword
  import aes_dk_pkg::*;
(
  input  word_t din,
  output word_t dout
);
  for (genvar b = 0; b < WORD_W / 8; b++) begin : g_byte
    assign dout[8*b +: 8] = sbox_f(din[8*b +: 8]);
  end
endmodule

// File: rtl/aes_dk_nextword.sv
module aes_dk_nextword
  import aes_dk_pkg::*;
(
  input  word_t      prev,
  input  word_t      far,
  input  logic [7:0] rcon,
  input  logic       is_round,
  input  logic       is_half,
  output word_t      nxt
);
  word_t sub_in, sub_out, mixed;

  assign sub_in = is_round ? rot_word(prev) : prev;

  aes_dk_subword u_sub (.din(sub_in), .dout(sub_out));

  always_comb begin
    if (is_round)     mixed = sub_out ^ {rcon, 24'h000000};
    else if (is_half) mixed = sub_out;
    else              mixed = prev;
  end

  assign nxt = far ^ mixed;
endmodule

// File: rtl/aes_dk_seq.sv
module aes_dk_seq
  import aes_dk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [1:0]       key_code,
  input  logic             start,
  output logic             busy,
  output logic             valid,
  output logic             err,
  output logic [1:0]       len_q,
  output logic [IDX_W-1:0] idx,
  output logic [2:0]       pos,
  output logic [7:0]       rcon,
  output logic             load_ok,
  output logic             start_ok,
  output logic             step_fire,
  output logic             last_step
);
  logic dirty;
  logic load_bad;
  logic [3:0] nk_q;

  assign nk_q      = nk_of(len_q);
  assign load_ok   = key_load && (key_code != KL_BAD);
  assign load_bad  = key_load && (key_code == KL_BAD);
  assign start_ok  = start && dirty && !busy && !load_ok;
  assign step_fire = busy && !load_ok;
  assign last_step = step_fire && (idx == last_idx(len_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      err   <= 1'b0;
      dirty <= 1'b0;
      len_q <= KL_128;
      idx   <= '0;
      pos   <= '0;
      rcon  <= 8'h01;
    end else begin
      err <= load_bad;
      if (load_ok) begin
        len_q <= key_code;
        dirty <= 1'b1;
        valid <= 1'b0;
        busy  <= 1'b0;
      end else if (busy) begin
        if (last_step) begin
          busy  <= 1'b0;
          valid <= 1'b1;
          dirty <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          pos <= (pos == 3'(nk_q - 4'd1)) ? 3'd0 : pos + 3'd1;
          if (pos == 3'd0) rcon <= xtime(rcon);
        end
      end else if (start_ok) begin
        busy <= 1'b1;
        idx  <= IDX_W'(nk_q);
        pos  <= 3'd0;
        rcon <= 8'h01;
      end
    end
  end
endmodule

// File: rtl/aes_dkey_extract.sv
module aes_dkey_extract
  import aes_dk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [1:0]       key_code,
  input  logic [KEY_W-1:0] key_data,
  input  logic             start,
  output logic             busy,
  output logic             dkey_valid,
  output logic             load_err,
  output logic [KEY_W-1:0] dkey_out
);
  logic [1:0]       len_q;
  logic [IDX_W-1:0] idx;
  logic [2:0]       pos;
  logic [7:0]       rcon;
  logic             load_ok, start_ok, step_fire, last_step;
  logic             is_round, is_half;
  wvec_t            win;
  word_t            far, nxt;
  word_t            slot [OUT_WORDS];

  aes_dk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_code(key_code),
    .start(start), .busy(busy), .valid(dkey_valid), .err(load_err),
    .len_q(len_q), .idx(idx), .pos(pos), .rcon(rcon), .load_ok(load_ok),
    .start_ok(start_ok), .step_fire(step_fire), .last_step(last_step)
  );

  always_comb begin
    case (len_q)
      KL_128:  far = win[OUT_WORDS-4];
      KL_192:  far = win[OUT_WORDS-6];
      default: far = win[OUT_WORDS-8];
    endcase
  end

  assign is_round = (pos == 3'd0);
  assign is_half  = (len_q == KL_256) && (pos == 3'd4);

  aes_dk_nextword u_next (
    .prev(win[OUT_WORDS-1]), .far(far), .rcon(rcon),
    .is_round(is_round), .is_half(is_half), .nxt(nxt)
  );

  // sliding window of the most recent schedule words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else if (load_ok) begin
      win <= load_win(key_data, key_code);
    end else if (step_fire) begin
      win <= {nxt, win[OUT_WORDS-1:1]};
    end
  end

  for (genvar j = 0; j < OUT_WORDS; j++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                     slot[j] <= '0;
      else if (start_ok)                              slot[j] <= '0;
      else if (step_fire && idx == slot_src(len_q, j)) slot[j] <= nxt;
    end
    assign dkey_out[KEY_W-1-WORD_W*j -: WORD_W] = slot[j];
  end
endmodule

// File: rtl/aes_dk_checker.sv
module aes_dk_checker
  import aes_dk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             key_load,
  input logic [1:0]       key_code,
  input logic             start,
  input logic             busy,
  input logic             dkey_valid,
  input logic             load_err,
  input logic [KEY_W-1:0] dkey_out,
  input logic [1:0]       len_q,
  input logic             last_step
);
  logic [6:0] run_cnt;
  logic [6:0] run_exp;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 7'd1;
    else           run_cnt <= '0;
  end

  always_comb begin
    case (len_q)
      KL_128:  run_exp = 7'd39;
      KL_192:  run_exp = 7'd45;
      default: run_exp = 7'd51;
    endcase
  end

  assert_reject_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && key_code == KL_BAD) |=> load_err);
  assert_no_stray_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_load && key_code == KL_BAD) |=> !load_err);
  assert_reject_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && key_code == KL_BAD && !busy && !start) |=> ($stable(dkey_valid) && $stable(dkey_out)));
  assert_load_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && key_code != KL_BAD) |=> (!dkey_valid && !busy));
  assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dkey_valid && !key_load) |=> (!busy && dkey_valid && $stable(dkey_out)));
  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> (run_cnt == run_exp));
  assert_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (dkey_valid && !busy));
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dkey_valid && len_q == KL_128) |-> (dkey_out[KEY_W/2-1:0] == '0));
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && dkey_valid));
endmodule

bind aes_dkey_extract aes_dk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_code(key_code),
  .start(start), .busy(busy), .dkey_valid(dkey_valid), .load_err(load_err),
  .dkey_out(dkey_out), .len_q(len_q), .last_step(last_step)
);

// File: tb/tb_aes_dkey_extract.sv
module tb_aes_dkey_extract;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [1:0]   key_code = 2'd0;
  logic [255:0] key_data = '0;
  logic         start = 1'b0;
  logic         busy, dkey_valid, load_err;
  logic [255:0] dkey_out;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  aes_dkey_extract dut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_code(key_code),
    .key_data(key_data), .start(start), .busy(busy), .dkey_valid(dkey_valid),
    .load_err(load_err), .dkey_out(dkey_out)
  );

  // ---------------- reference arithmetic ----------------
  logic [7:0] sb [256];

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 0;
      logic [7:0] s;
      if (v != 0)
        for (int u = 1; u < 256; u++)
          if (fmul(8'(v), 8'(u)) == 8'h01) inv = 8'(u);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i & 1'b1;
      sb[v] = s;
    end
  endtask

  function automatic logic [255:0] expect_out(input logic [255:0] k, input logic [1:0] code);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    logic [255:0] r = '0;
    int nk = (code == 0) ? 4 : (code == 1) ? 6 : 8;
    int total = 4 * (nk + 7);
    for (int i = 0; i < nk; i++) w[i] = k[255 - 32*i -: 32];
    for (int i = nk; i < total; i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = fmul(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) begin
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
      end
      w[i] = w[i-nk] ^ t;
    end
    if (code == 0) begin
      r[255:128] = {w[40], w[41], w[42], w[43]};
    end else if (code == 1) begin
      r = {w[48], w[49], w[50], w[51], w[46], w[47], w[48], w[49]};
    end else begin
      r = {w[56], w[57], w[58], w[59], w[52], w[53], w[54], w[55]};
    end
    return r;
  endfunction

  // ---------------- behavioural state model ----------------
  logic [255:0] m_key = '0;
  logic [1:0]   m_code = 0;
  bit m_dirty = 0, m_busy = 0, m_valid = 0, m_err = 0;
  int m_cnt = 0;
  logic [255:0] m_out = '0;

  task automatic model_update(input bit ld, input logic [1:0] code, input logic [255:0] kd, input bit st);
    m_err = ld && code == 2'd3;
    if (ld && code != 2'd3) begin
      m_key = kd; m_code = code; m_dirty = 1; m_valid = 0; m_busy = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_valid = 1; m_dirty = 0;
        m_out = expect_out(m_key, m_code);
      end
    end else if (st && m_dirty) begin
      m_busy = 1;
      m_cnt = (m_code == 0) ? 40 : (m_code == 1) ? 46 : 52;
    end
  endtask

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp_v);
    vectors++;
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, act, exp_v);
    end
  endtask

  task automatic compare();
    check("R1 load_err", 256'(load_err), 256'(m_err));
    check("R4 busy (R3)", 256'(busy), 256'(m_busy));
    check("R2 dkey_valid (R9)", 256'(dkey_valid), 256'(m_valid));
    if (m_valid) begin
      if (m_code == 0)      check("R6 output (R5)", dkey_out, m_out);
      else if (m_code == 1) check("R7 output (R5)", dkey_out, m_out);
      else                  check("R8 output (R5)", dkey_out, m_out);
    end
  endtask

  task automatic cycle(input bit ld, input logic [1:0] code, input logic [255:0] kd, input bit st);
    key_load = ld; key_code = code; key_data = kd; start = st;
    @(posedge clk);
    model_update(ld, code, kd, st);
    @(negedge clk);
    key_load = 0; start = 0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 2'd0, '0, 0);
  endtask

  function automatic logic [255:0] rnd_key();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[32*i +: 32] = $urandom;
    return k;
  endfunction

  task automatic derive(input logic [1:0] code, input logic [255:0] k);
    cycle(1, code, k, 0);
    cycle(0, 2'd0, '0, 1);
    for (int i = 0; i < 60 && m_busy; i++) idle(1);
    idle(1);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog R4: got no finish, expected end before cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check("R9 reset busy", 256'(busy), 256'(0));
    check("R9 reset valid", 256'(dkey_valid), 256'(0));
    check("R9 reset load_err", 256'(load_err), 256'(0));
    check("R9 reset dkey_out", dkey_out, '0);

    // R3: start with no key loaded is ignored
    cycle(0, 2'd0, '0, 1);
    idle(2);

    // R5/R6: known 128-bit key, last round key words
    derive(2'd0, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0});
    check("R5 known 128-bit round key (R6)", dkey_out,
          {128'hd014f9a8c9ee2589e13f0cc8b6630ca6, 128'h0});
    // R3: restart with flag clear has no effect
    cycle(0, 2'd0, '0, 1);
    idle(3);
    // R1: illegal code while valid leaves state
    cycle(1, 2'd3, rnd_key(), 0);
    idle(2);
    cycle(0, 2'd0, '0, 1);
    idle(2);

    // R7, R8
    derive(2'd1, rnd_key());
    derive(2'd2, rnd_key());

    // R2: reload mid-run abandons it; R1 reject while busy
    cycle(1, 2'd2, rnd_key(), 0);
    cycle(0, 2'd0, '0, 1);
    idle(10);
    cycle(1, 2'd3, rnd_key(), 0);
    idle(5);
    cycle(1, 2'd1, rnd_key(), 0);
    idle(3);
    cycle(0, 2'd0, '0, 1);
    cycle(0, 2'd0, '0, 1);   // start while busy: ignored
    for (int i = 0; i < 50; i++) idle(1);
    // R1: illegal load together with a start
    cycle(1, 2'd2, rnd_key(), 0);
    cycle(1, 2'd3, rnd_key(), 1);
    for (int i = 0; i < 56; i++) idle(1);

    // random keys for every length
    for (int r = 0; r < 4; r++) begin
      derive(2'd0, rnd_key());
      derive(2'd1, rnd_key());
      derive(2'd2, rnd_key());
    end
    finish_run();
  end
endmodule